// File: doc/BRIEF.md
# LED Frame Sequencer

This block is the central state machine between a command receiver, a byte-wide pixel memory and a serial LED bit encoder. In its idle state it watches a one-cycle command strobe. A write stores one byte, and a read returns one byte on the next cycle. A clear sweeps every memory location with zeros and a fill sweeps it with a given byte. Both sweeps run at one address per clock. A send streams a number of 24-bit pixels to the encoder.

During a send the sequencer fetches the three bytes of the next pixel ahead of time and assembles them into one word. It hands this word over only when the encoder asks for it. The encoder request is a level that the encoder holds until it sees the one-cycle load pulse. After the last pixel the sequencer waits for one more request, which means that the encoder has shifted out the final bit. It then releases the active-low send enable and holds a latch gap of fixed length. Only after the gap does it accept commands again.

States and transitions: IDLE goes to SWEEP on clear or fill, and to FETCH on a send with a non-zero count. Other opcodes and a zero count keep it in IDLE. SWEEP goes back to IDLE after the last address. FETCH goes to HOLD after three reads. HOLD goes to FETCH on a request for a pixel that is not the last one, and to DRAIN on the request for the last one. DRAIN goes to GAP on the next request. GAP goes to IDLE when the gap timer expires.

Top module: `led_frame_sequencer`

## Requirements
- R1: After reset the block is idle: `enc_send_n` is 1, and `rd_valid` and `enc_load` are 0.
- R2: A strobe with `cmd_op` = 3'b100 writes `cmd_data` to `cmd_addr` at that clock edge. A read issued in the very next cycle returns the new byte.
- R3: A strobe with `cmd_op` = 3'b000 raises `rd_valid` for one cycle, one clock later, with `rd_data` holding the byte at `cmd_addr`.
- R4: A strobe with `cmd_op` = 3'b011 writes zero to every address, one address per clock. It takes exactly DEPTH cycles, and the first cycle after it accepts commands.
- R5: A strobe with `cmd_op` = 3'b101 writes `cmd_data` to every address, with the same DEPTH-cycle timing as R4.
- R6: A strobe with `cmd_op` = 3'b111 sends pixels in order. Pixel n is {byte 3n, byte 3n+1, byte 3n+2}, and the first byte goes in bits 23:16. Each pixel is presented on `enc_pixel` together with a one-cycle `enc_load`, and only in answer to `enc_req`.
- R7: Exactly `cmd_count` pixels are loaded. The next request after the last load raises `enc_send_n`. Exactly RESET_CYCLES cycles of latch gap follow before a command is accepted.
- R8: `enc_send_n` is 0 from the cycle after the send strobe until the final release.
- R9: A send with `cmd_count` = 0 leaves `enc_send_n` at 1, and the block accepts a command in the next cycle.
- R10: Strobes that arrive during a sweep, a send or the latch gap have no effect.
- R11: Opcodes 3'b001, 3'b010 and 3'b110 are ignored. They cause no read, no write and no send.
- R12: Addresses at or above DEPTH hold no storage. Writes to them are dropped, and reads of them, including the bytes fetched for a pixel, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | 13 | Byte address for read and write |
| cmd_data | input | 8 | Write byte or fill byte |
| cmd_count | input | 13 | Number of pixels to send |
| rd_valid | output | 1 | Read result valid, one cycle |
| rd_data | output | 8 | Read result byte |
| enc_req | input | 1 | Encoder asks for the next pixel (held until load) |
| enc_load | output | 1 | One-cycle pulse: `enc_pixel` has been updated |
| enc_pixel | output | 24 | Pixel word for the encoder |
| enc_send_n | output | 1 | Active-low send enable for the encoder |

## Verification
On every cycle the assertions check several rules. Memory is never written while the send enable is low. A load always answers a request. The enable rises only on a request. A read result follows a read strobe. Sweep addresses advance by one each cycle. The pixel counter never passes its total, and a zero-count send never leaves idle. Other behaviour can only be shown by the bench's scenarios: the byte order inside each pixel, the exact number of pixels, the exact lengths of the sweep and the latch gap (probed by strobes one cycle either side of the end), zero bytes past the end of memory, and strobes that were dropped without effect.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

    localparam int ADDR_W      = 13;
    localparam int BYTE_W      = 8;
    localparam int PIXEL_BYTES = 3;
    localparam int PIXEL_W     = BYTE_W * PIXEL_BYTES;

    localparam logic [2:0] OP_READ  = 3'b000;
    localparam logic [2:0] OP_CLEAR = 3'b011;
    localparam logic [2:0] OP_WRITE = 3'b100;
    localparam logic [2:0] OP_FILL  = 3'b101;
    localparam logic [2:0] OP_SEND  = 3'b111;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SWEEP,
        S_FETCH,
        S_HOLD,
        S_DRAIN,
        S_GAP
    } seq_state_e;

endpackage

// File: rtl/lfs_byte_ram.sv
module lfs_byte_ram #(
    parameter int DEPTH = 1024,
    parameter int AW    = 13,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic          in_range;

    assign in_range = (32'(addr) < DEPTH);

    always_ff @(posedge clk) begin
        if (we && in_range) begin
            mem[addr[IDX_W-1:0]] <= wdata;
        end
        q <= in_range ? mem[addr[IDX_W-1:0]] : '0;
    end
endmodule

// File: rtl/lfs_pixel_packer.sv
module lfs_pixel_packer #(
    parameter int DW    = 8,
    parameter int BYTES = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic [DW-1:0]       din,
    output logic [DW*BYTES-1:0] word
);
    localparam int WW = DW * BYTES;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[WW-DW-1:0], din};
        end
    end
endmodule

// File: rtl/lfs_gap_timer.sv
module lfs_gap_timer #(
    parameter int CYCLES = 3200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic last
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == CW'(1));
endmodule

// File: rtl/led_frame_sequencer.sv
module led_frame_sequencer
    import lfs_pkg::*;
#(
    parameter int DEPTH        = 1024,
    parameter int RESET_CYCLES = 3200
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_op,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [BYTE_W-1:0]   cmd_data,
    input  logic [ADDR_W-1:0]   cmd_count,
    output logic                rd_valid,
    output logic [BYTE_W-1:0]   rd_data,
    input  logic                enc_req,
    output logic                enc_load,
    output logic [PIXEL_W-1:0]  enc_pixel,
    output logic                enc_send_n
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
    localparam logic [1:0]        LAST_BYTE = 2'(PIXEL_BYTES - 1);

    seq_state_e state, state_nxt;

    logic [ADDR_W-1:0]  ptr;
    logic [1:0]         byte_idx;
    logic               rd_pend;
    logic [ADDR_W-1:0]  led_cnt;
    logic [ADDR_W-1:0]  led_total;
    logic [BYTE_W-1:0]  fill_byte;

    logic               ram_we;
    logic [ADDR_W-1:0]  ram_addr;
    logic [BYTE_W-1:0]  ram_wdata;
    logic [BYTE_W-1:0]  ram_q;
    logic [PIXEL_W-1:0] packed_word;
    logic               gap_start;
    logic               gap_last;

    logic idle_cmd, word_ready, take, last_pixel;

    assign idle_cmd   = (state == S_IDLE) && cmd_valid;
    assign word_ready = (state == S_HOLD) && !rd_pend;
    assign take       = word_ready && enc_req;
    assign last_pixel = ((led_cnt + 1'b1) == led_total);
    assign gap_start  = (state == S_DRAIN) && enc_req;

    // next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_op == OP_CLEAR || cmd_op == OP_FILL) begin
                        state_nxt = S_SWEEP;
                    end else if (cmd_op == OP_SEND && cmd_count != '0) begin
                        state_nxt = S_FETCH;
                    end
                end
            end
            S_SWEEP: if (ptr == LAST_ADDR)     state_nxt = S_IDLE;
            S_FETCH: if (byte_idx == LAST_BYTE) state_nxt = S_HOLD;
            S_HOLD:  if (take)                 state_nxt = last_pixel ? S_DRAIN : S_FETCH;
            S_DRAIN: if (enc_req)              state_nxt = S_GAP;
            S_GAP:   if (gap_last)             state_nxt = S_IDLE;
            default:                           state_nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr       <= '0;
            byte_idx  <= '0;
            rd_pend   <= 1'b0;
            led_cnt   <= '0;
            led_total <= '0;
            fill_byte <= '0;
            rd_valid  <= 1'b0;
            enc_load  <= 1'b0;
            enc_pixel <= '0;
        end else begin
            rd_valid <= idle_cmd && (cmd_op == OP_READ);
            enc_load <= take;
            rd_pend  <= (state == S_FETCH);
            unique case (state)
                S_IDLE: begin
                    ptr      <= '0;
                    byte_idx <= '0;
                    led_cnt  <= '0;
                    if (idle_cmd) begin
                        fill_byte <= (cmd_op == OP_FILL) ? cmd_data : '0;
                        led_total <= cmd_count;
                    end
                end
                S_SWEEP: ptr <= ptr + 1'b1;
                S_FETCH: begin
                    ptr      <= ptr + 1'b1;
                    byte_idx <= byte_idx + 1'b1;
                end
                S_HOLD: begin
                    if (take) begin
                        enc_pixel <= packed_word;
                        led_cnt   <= led_cnt + 1'b1;
                        byte_idx  <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // memory port steering
    always_comb begin
        ram_we    = 1'b0;
        ram_addr  = ptr;
        ram_wdata = fill_byte;
        if (state == S_IDLE) begin
            ram_addr  = cmd_addr;
            ram_wdata = cmd_data;
            ram_we    = cmd_valid && (cmd_op == OP_WRITE);
        end else if (state == S_SWEEP) begin
            ram_we = 1'b1;
        end
    end

    assign rd_data    = ram_q;
    assign enc_send_n = !((state == S_FETCH) || (state == S_HOLD) || (state == S_DRAIN));

    lfs_byte_ram #(.DEPTH(DEPTH), .AW(ADDR_W), .DW(BYTE_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .q     (ram_q)
    );

    lfs_pixel_packer #(.DW(BYTE_W), .BYTES(PIXEL_BYTES)) u_packer (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (rd_pend),
        .din      (ram_q),
        .word     (packed_word)
    );

    lfs_gap_timer #(.CYCLES(RESET_CYCLES)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .start (gap_start),
        .last  (gap_last)
    );
endmodule

// File: rtl/lfs_checker.sv
module lfs_checker
    import lfs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_count,
    input logic              rd_valid,
    input logic              enc_req,
    input logic              enc_load,
    input logic              enc_send_n,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input seq_state_e        state,
    input logic [ADDR_W-1:0] led_cnt,
    input logic [ADDR_W-1:0] led_total
);
    // R3
    rd_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_valid && cmd_op == OP_READ && state == S_IDLE));

    // R10
    no_write_in_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_send_n |-> !ram_we);

    // R6
    load_answers_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_load |-> ($past(enc_req) && !enc_send_n));

    // R7
    release_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enc_send_n) |-> $past(enc_req));

    // R9
    zero_count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && cmd_valid && cmd_op == OP_SEND && cmd_count == '0)
        |=> (enc_send_n && state == S_IDLE));

    // R4
    sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SWEEP && $past(state == S_SWEEP))
        |-> (ram_addr == ADDR_W'($past(ram_addr) + 1'b1)));

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        led_cnt <= led_total);
endmodule

bind led_frame_sequencer lfs_checker u_lfs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_count  (cmd_count),
    .rd_valid   (rd_valid),
    .enc_req    (enc_req),
    .enc_load   (enc_load),
    .enc_send_n (enc_send_n),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .state      (state),
    .led_cnt    (led_cnt),
    .led_total  (led_total)
);

// File: tb/test_led_frame_sequencer.sv
module test_led_frame_sequencer;
    localparam int DEPTH = 96;
    localparam int GAP   = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'b000;
    logic [12:0] cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic [12:0] cmd_count = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        enc_req = 1'b0;
    logic        enc_load;
    logic [23:0] enc_pixel;
    logic        enc_send_n;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;
    logic [7:0] model [DEPTH];

    always #4 clk = ~clk;

    led_frame_sequencer #(.DEPTH(DEPTH), .RESET_CYCLES(GAP)) i_led_frame_sequencer (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_count(cmd_count),
        .rd_valid(rd_valid), .rd_data(rd_data), .enc_req(enc_req),
        .enc_load(enc_load), .enc_pixel(enc_pixel), .enc_send_n(enc_send_n)
    );

    function automatic logic [7:0] mbyte(input int a);
        return (a < DEPTH) ? model[a] : 8'h00;
    endfunction

    function automatic logic [23:0] exp_pixel(input int n);
        return {mbyte(3*n), mbyte(3*n+1), mbyte(3*n+2)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // all command tasks are entered just after a falling edge
    task automatic do_cmd(input logic [2:0] op, input int a, input logic [7:0] d, input int cnt);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = 13'(a); cmd_data = d; cmd_count = 13'(cnt);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_write(input int a, input logic [7:0] d, input bit accepted);
        do_cmd(3'b100, a, d, 0);
        if (accepted && a < DEPTH) model[a] = d;
    endtask

    task automatic do_read(input int a, input string req);
        do_cmd(3'b000, a, 8'h00, 0);
        check(rd_valid == 1'b1, req, "rd_valid", 32'(rd_valid), 32'd1);
        check(rd_data == mbyte(a), req, "rd_data", 32'(rd_data), 32'(mbyte(a)));
    endtask

    task automatic sweep_test(input logic [2:0] op, input logic [7:0] d, input string req);
        do_cmd(op, 0, d, 0);
        repeat (9) @(negedge clk);
        do_write(0, 8'h77, 1'b0);                 // mid-sweep strobe, R10
        repeat (DEPTH - 11) @(negedge clk);
        do_write(5, 8'h3C, 1'b0);                 // last sweep cycle: dropped
        for (int i = 0; i < DEPTH; i++) model[i] = d;
        do_write(6, 8'hC3, 1'b1);                 // first idle cycle: taken
        for (int i = 0; i < DEPTH; i++) do_read(i, req);
    endtask

    task automatic send_test(input int cnt);
        int  tgt;
        bit  seen;
        int  extra;
        logic [7:0] tval;
        tgt = (3*(cnt-1) < DEPTH) ? 3*(cnt-1) : 1;
        tval = ~model[tgt];
        do_cmd(3'b111, 0, 8'h00, cnt);
        check(enc_send_n == 1'b0, "R8", "send_n after strobe", 32'(enc_send_n), 32'd0);
        for (int i = 0; i < cnt; i++) begin
            enc_req = 1'b1;
            seen = 1'b0;
            for (int w = 0; w < 20 && !seen; w++) begin
                @(negedge clk);
                if (enc_load) seen = 1'b1;
            end
            enc_req = 1'b0;
            check(seen, "R6", "load seen", 32'(seen), 32'd1);
            check(enc_pixel == exp_pixel(i), (3*i+2 >= DEPTH) ? "R12" : "R6",
                  "pixel", 32'(enc_pixel), 32'(exp_pixel(i)));
            if (i == 0) do_write(tgt, tval, 1'b0);  // R10: strobe during send
            for (int w = 0; w < 2 + int'($urandom_range(4, 0)); w++) begin
                @(negedge clk);
                check(enc_load == 1'b0, "R6", "unrequested load", 32'(enc_load), 32'd0);
                check(enc_send_n == 1'b0, "R8", "send_n held", 32'(enc_send_n), 32'd0);
            end
        end
        enc_req = 1'b1;
        extra = 0;
        for (int w = 0; w < 10 && enc_send_n == 1'b0; w++) begin
            @(negedge clk);
            if (enc_load) extra++;
        end
        enc_req = 1'b0;
        check(enc_send_n == 1'b1, "R7", "release", 32'(enc_send_n), 32'd1);
        check(extra == 0, "R7", "loads beyond count", 32'(extra), 32'd0);
        repeat (GAP - 1) @(negedge clk);
        do_write(7, ~mbyte(7), 1'b0);              // last gap cycle: dropped
        do_write(8, ~mbyte(8), 1'b1);              // first idle cycle: taken
        do_read(7, "R7");
        do_read(8, "R7");
        do_read(tgt, "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20511));
        repeat (3) @(negedge clk);
        check(enc_send_n == 1'b1, "R1", "send_n in reset", 32'(enc_send_n), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check(enc_send_n == 1'b1, "R1", "send_n", 32'(enc_send_n), 32'd1);
        check(rd_valid == 1'b0, "R1", "rd_valid", 32'(rd_valid), 32'd0);
        check(enc_load == 1'b0, "R1", "enc_load", 32'(enc_load), 32'd0);

        sweep_test(3'b011, 8'h00, "R4");
        sweep_test(3'b101, 8'hA5, "R5");

        // random single-byte traffic, including out-of-range addresses
        for (int i = 0; i < 80; i++) begin
            int a;
            a = int'($urandom_range(DEPTH + 15, 0));
            do_write(a, 8'($urandom()), 1'b1);
            do_read(a, (a >= DEPTH) ? "R12" : "R2");
            do_read(int'($urandom_range(DEPTH - 1, 0)), "R3");
        end

        // undefined opcodes
        foreach (model[i]) begin end
        for (int k = 0; k < 3; k++) begin
            logic [2:0] op;
            op = (k == 0) ? 3'b001 : (k == 1) ? 3'b010 : 3'b110;
            do_cmd(op, 10, ~mbyte(10), 2);
            check(rd_valid == 1'b0, "R11", "rd_valid", 32'(rd_valid), 32'd0);
            check(enc_send_n == 1'b1, "R11", "send_n", 32'(enc_send_n), 32'd1);
            do_read(10, "R11");
        end

        // zero-length send
        do_cmd(3'b111, 0, 8'h00, 0);
        check(enc_send_n == 1'b1, "R9", "send_n", 32'(enc_send_n), 32'd1);
        do_write(20, 8'h5A, 1'b1);
        check(enc_send_n == 1'b1, "R9", "send_n later", 32'(enc_send_n), 32'd1);
        do_read(20, "R9");

        // distinct pixel data everywhere
        for (int i = 0; i < DEPTH; i++) do_write(i, 8'($urandom()), 1'b1);

        send_test(1);
        send_test(3);
        for (int k = 0; k < 3; k++) send_test(2 + int'($urandom_range(4, 0)));
        send_test(34);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule